// File: doc/BRIEF.md
# Amplifier Power-Up Pin Arbiter

This block merges the external-amplifier power-up requests of several audio port widgets into one level for a shared bidirectional control pin. Each port asks for power only when its own enable bit is set and it is either awake (port and function group both in D0 or D1) or carrying analog beep as an output. The requests are ORed. A configuration register then decides whether the pin behaves as an open-drain line, a push-pull output or a plain input.

The same pin doubles as the mute/shutdown input of an internal bridge-tied-load amplifier. The sensed pad level is synchronized and, by default, turns the internal amplifier on or off. A control-source flag can instead tie the internal amplifier to the power states of one chosen port and of the function group. The pin-mode and control-source settings survive link and function-group resets. Only power-on reset clears them.

Top module: `amp_pwr_arbiter`

## Requirements
- R1: Port i (enable bit i of the enable vector, power state in bits 2i+1:2i of the port-state bus, encoded D0=0, D1=1, D2=2, D3=3) raises a request only when its enable bit is 1 and either (function-group state and its own state are both D0 or D1) or (beep is enabled and its output flag is 1).
- R2: The pin request is the OR of the requests of all ports. Clearing one port's enable leaves the pin requested while another port still requests.
- R3: Either reset sets every port enable bit to 1 and holds the pad at drive-low (output enable 1, drive value 0). With the function group in D3 the pad stays low after reset. Internal amplifier enable resets to 0.
- R4: Pin mode 00 (open-drain, the default) drives the pad low when no port requests. It releases the pad (output enable 0) when any port requests. The drive value is never 1.
- R5: Pin mode 01 (push-pull) keeps output enable at 1 and drives the request level onto the pad.
- R6: Pin modes 10 and 11 (input) keep output enable at 0 whatever the enable bits and requests are.
- R7: With control source 0, the internal amplifier enable follows the sensed pad level. This includes a low forced by an external device while the pad is released. The enable is updated through a two-flop synchronizer and one output register, so it settles three clocks after the pad level changes.
- R8: With control source 1, the internal amplifier enable is 1 exactly when the function group and the selected port (parameter AMP_PORT, default 0) are both in D0 or D1. The pad level has no effect.
- R9: Link reset leaves the pin mode and control source unchanged. Power-on reset returns them to mode 00 and control source 0.
- R10: Pad drive value and output enable are registered and reflect the inputs one clock after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears everything |
| link_rst | input | 1 | Link / function-group reset, synchronous, active high; keeps configuration |
| cfg_we | input | 1 | Write strobe for pin mode and control source |
| cfg_mode_d | input | 2 | Pin mode to write: 00 open-drain, 01 push-pull, 1x input |
| cfg_src_d | input | 1 | Control source to write: 0 pad level, 1 power states |
| en_we | input | 1 | Write strobe for the port enable vector |
| en_d | input | NUM_PORTS | Port enable bits to write |
| fg_ps | input | 2 | Function-group power state |
| port_ps | input | 2*NUM_PORTS | Per-port power states, port i in bits 2i+1:2i |
| beep_en | input | 1 | Analog beep enabled |
| port_out_en | input | NUM_PORTS | Per-port output-direction flag |
| pad_in | input | 1 | Sensed pad level (asynchronous) |
| pad_do | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad output enable |
| amp_en | output | 1 | Internal amplifier enable (0 = mute/shutdown) |

## Verification
The request path is exercised one port at a time. Each port is given states D0, D1, D2 and D3 with its enable set and cleared, which separates the power-state term from the enable gate. The beep path is driven with the function group asleep, so it cannot be mistaken for the power-state term. Two ports requesting together, with one then disabled, distinguish an OR from a single-port selection. Each pin mode is run with a request present and absent, and in the input modes the request conditions are toggled to show they have no effect. In open-drain and input modes an external device pulls the pad low to show that the internal amplifier follows the pad and not the request. With the control source set to 1, the same low pull and a sleeping selected port show that the pad is no longer consulted. Link and power-on resets are applied over a non-default configuration to tell the two reset domains apart.

// File: rtl/amp_pwr_pkg.sv
package amp_pwr_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    PIN_OPEN_DRAIN = 2'b00,
    PIN_PUSH_PULL  = 2'b01,
    PIN_IN_A       = 2'b10,
    PIN_IN_B       = 2'b11
  } pin_mode_e;

  localparam int PS_W = 2;

  function automatic logic ps_awake(input logic [PS_W-1:0] ps);
    return (ps == PS_D0) || (ps == PS_D1);
  endfunction

endpackage

// File: rtl/amp_pwr_cfg.sv
module amp_pwr_cfg
  import amp_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 por_rst,
  input  logic                 link_rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_mode_d,
  input  logic                 cfg_src_d,
  input  logic                 en_we,
  input  logic [NUM_PORTS-1:0] en_d,
  output pin_mode_e            pin_mode,
  output logic                 ctl_src,
  output logic [NUM_PORTS-1:0] port_en
);

  // Pin configuration: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (por_rst) begin
      pin_mode <= PIN_OPEN_DRAIN;
      ctl_src  <= 1'b0;
    end else if (cfg_we) begin
      pin_mode <= pin_mode_e'(cfg_mode_d);
      ctl_src  <= cfg_src_d;
    end
  end

  // Port enables: any reset sets them all
  always_ff @(posedge clk) begin
    if (por_rst || link_rst) begin
      port_en <= '1;
    end else if (en_we) begin
      port_en <= en_d;
    end
  end

  // R9: link reset must not disturb the pin configuration
  a_r9_cfg_kept: assert property (@(posedge clk) disable iff (por_rst)
    (link_rst && !cfg_we) |=> ($stable(pin_mode) && $stable(ctl_src)));

  // R3: enables come back as all ones after a link reset
  a_r3_en_reset: assert property (@(posedge clk) disable iff (por_rst)
    link_rst |=> (port_en == {NUM_PORTS{1'b1}}));

endmodule

// File: rtl/amp_pwr_req.sv
module amp_pwr_req
  import amp_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PORTS-1:0]      port_en,
  input  logic [PS_W-1:0]           fg_ps,
  input  logic [PS_W*NUM_PORTS-1:0] port_ps,
  input  logic                      beep_en,
  input  logic [NUM_PORTS-1:0]      port_out_en,
  output logic [NUM_PORTS-1:0]      port_req,
  output logic                      req_any
);

  logic fg_awake;
  assign fg_awake = ps_awake(fg_ps);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic awake_i;
    assign awake_i     = fg_awake && ps_awake(port_ps[PS_W*i +: PS_W]);
    assign port_req[i] = port_en[i] && (awake_i || (beep_en && port_out_en[i]));
  end

  assign req_any = |port_req;

  // R1: with the function group asleep and beep off no port may request
  a_r1_asleep_quiet: assert property (@(posedge clk) disable iff (rst)
    (!fg_awake && !beep_en) |-> !req_any);

  // R1: a disabled port never requests
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (port_req & ~port_en) == '0);

endmodule

// File: rtl/amp_pwr_sync.sv
module amp_pwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else begin
      shreg <= {shreg[STAGES-2:0], d};
    end
  end

  assign q = shreg[STAGES-1];

endmodule

// File: rtl/amp_pwr_arbiter.sv
module amp_pwr_arbiter
  import amp_pwr_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int AMP_PORT    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          por_rst,
  input  logic                          link_rst,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_mode_d,
  input  logic                          cfg_src_d,
  input  logic                          en_we,
  input  logic [NUM_PORTS-1:0]          en_d,
  input  logic [1:0]                    fg_ps,
  input  logic [2*NUM_PORTS-1:0]        port_ps,
  input  logic                          beep_en,
  input  logic [NUM_PORTS-1:0]          port_out_en,
  input  logic                          pad_in,
  output logic                          pad_do,
  output logic                          pad_oe,
  output logic                          amp_en
);

  logic                 rst_any;
  pin_mode_e            pin_mode;
  logic                 ctl_src;
  logic [NUM_PORTS-1:0] port_en;
  logic [NUM_PORTS-1:0] port_req;
  logic                 req_any;
  logic                 pad_sync;
  logic                 amp_pwr_ok;

  assign rst_any = por_rst || link_rst;

  amp_pwr_cfg #(.NUM_PORTS(NUM_PORTS)) u_cfg (
    .clk        (clk),
    .por_rst    (por_rst),
    .link_rst   (link_rst),
    .cfg_we     (cfg_we),
    .cfg_mode_d (cfg_mode_d),
    .cfg_src_d  (cfg_src_d),
    .en_we      (en_we),
    .en_d       (en_d),
    .pin_mode   (pin_mode),
    .ctl_src    (ctl_src),
    .port_en    (port_en)
  );

  amp_pwr_req #(.NUM_PORTS(NUM_PORTS)) u_req (
    .clk         (clk),
    .rst         (rst_any),
    .port_en     (port_en),
    .fg_ps       (fg_ps),
    .port_ps     (port_ps),
    .beep_en     (beep_en),
    .port_out_en (port_out_en),
    .port_req    (port_req),
    .req_any     (req_any)
  );

  amp_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst_any),
    .d   (pad_in),
    .q   (pad_sync)
  );

  assign amp_pwr_ok = ps_awake(fg_ps) && ps_awake(port_ps[2*AMP_PORT +: 2]);

  always_ff @(posedge clk) begin
    if (rst_any) begin
      pad_do <= 1'b0;
      pad_oe <= 1'b1;
      amp_en <= 1'b0;
    end else begin
      unique case (pin_mode)
        PIN_OPEN_DRAIN: begin
          pad_do <= 1'b0;
          pad_oe <= !req_any;
        end
        PIN_PUSH_PULL: begin
          pad_do <= req_any;
          pad_oe <= 1'b1;
        end
        default: begin
          pad_do <= 1'b0;
          pad_oe <= 1'b0;
        end
      endcase
      amp_en <= ctl_src ? amp_pwr_ok : pad_sync;
    end
  end

  // R4: open-drain never drives a high level
  a_r4_od_no_high: assert property (@(posedge clk) disable iff (rst_any)
    (pin_mode == PIN_OPEN_DRAIN) |=> !pad_do);

  // R5: push-pull always drives
  a_r5_pp_drives: assert property (@(posedge clk) disable iff (rst_any)
    (pin_mode == PIN_PUSH_PULL) |=> pad_oe);

  // R6: input modes never drive
  a_r6_in_released: assert property (@(posedge clk) disable iff (rst_any)
    pin_mode[1] |=> !pad_oe);

  // R8: power-state control with the function group in D3 keeps the amp off
  a_r8_src_fg_off: assert property (@(posedge clk) disable iff (rst_any)
    (ctl_src && (fg_ps == PS_D3)) |=> !amp_en);

endmodule

// File: tb/amp_pwr_arbiter_tb_top.sv
module amp_pwr_arbiter_tb_top;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         por_rst = 1'b1;
  logic         link_rst = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_mode_d = 2'b00;
  logic         cfg_src_d = 1'b0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_d = '0;
  logic [1:0]   fg_ps = 2'd3;
  logic [2*N-1:0] port_ps = '1;
  logic         beep_en = 1'b0;
  logic [N-1:0] port_out_en = '0;
  logic         ext_drv = 1'b0;
  logic         ext_lvl = 1'b1;
  logic         pad_in;
  logic         pad_do, pad_oe, amp_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // pad model: weak pull-up, optional external driver
  assign pad_in = ext_drv ? ext_lvl : (pad_oe ? pad_do : 1'b1);

  amp_pwr_arbiter #(.NUM_PORTS(N)) dut_i (
    .clk(clk), .por_rst(por_rst), .link_rst(link_rst),
    .cfg_we(cfg_we), .cfg_mode_d(cfg_mode_d), .cfg_src_d(cfg_src_d),
    .en_we(en_we), .en_d(en_d), .fg_ps(fg_ps), .port_ps(port_ps),
    .beep_en(beep_en), .port_out_en(port_out_en), .pad_in(pad_in),
    .pad_do(pad_do), .pad_oe(pad_oe), .amp_en(amp_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic s);
    cfg_mode_d = m; cfg_src_d = s; cfg_we = 1'b1;
    wait_n(1);
    cfg_we = 1'b0;
  endtask

  task automatic set_en(input logic [N-1:0] v);
    en_d = v; en_we = 1'b1;
    wait_n(1);
    en_we = 1'b0;
  endtask

  task automatic set_ps(input int i, input logic [1:0] v);
    port_ps[2*i +: 2] = v;
  endtask

  task automatic quiet_inputs();
    fg_ps = 2'd3; port_ps = '1; beep_en = 1'b0; port_out_en = '0;
    ext_drv = 1'b0; ext_lvl = 1'b1;
  endtask

  task automatic t_reset();
    quiet_inputs();
    por_rst = 1'b1;
    wait_n(3);
    chk("R3 oe during reset", pad_oe, 1'b1);
    chk("R3 amp during reset", amp_en, 1'b0);
    por_rst = 1'b0;
    wait_n(2);
    chk("R3 oe after reset fg D3", pad_oe, 1'b1);
    chk("R3 do after reset fg D3", pad_do, 1'b0);
    wait_n(4);
    chk("R7 amp follows low pad", amp_en, 1'b0);
    // enables reset to ones: waking one port must release the pad
    fg_ps = 2'd0; set_ps(2, 2'd0);
    wait_n(2);
    chk("R3 enables reset to one", pad_oe, 1'b0);
    quiet_inputs();
    wait_n(2);
  endtask

  task automatic t_ports();
    for (int i = 0; i < N; i++) begin
      quiet_inputs();
      set_en('1);
      fg_ps = 2'd0; set_ps(i, 2'd1);
      wait_n(2);
      chk("R1 port D1 requests", pad_oe, 1'b0);
      set_ps(i, 2'd2);
      wait_n(2);
      chk("R1 port D2 no request", pad_oe, 1'b1);
      set_ps(i, 2'd0);
      set_en(~(N'(1) << i));
      wait_n(1);
      chk("R1 disabled port no request", pad_oe, 1'b1);
      set_en('1);
      fg_ps = 2'd2;
      wait_n(2);
      chk("R1 fg D2 blocks", pad_oe, 1'b1);
      fg_ps = 2'd3; beep_en = 1'b1; port_out_en = N'(1) << i;
      wait_n(2);
      chk("R1 beep output requests", pad_oe, 1'b0);
      beep_en = 1'b0;
      wait_n(2);
      chk("R1 beep off no request", pad_oe, 1'b1);
    end
    // R2: two ports, drop one
    quiet_inputs();
    fg_ps = 2'd0; set_ps(1, 2'd0); set_ps(3, 2'd1);
    set_en('1);
    wait_n(1);
    chk("R2 two ports request", pad_oe, 1'b0);
    set_en(4'b0111);
    wait_n(1);
    chk("R2 one still requests", pad_oe, 1'b0);
    set_en(4'b0101);
    wait_n(1);
    chk("R2 none requests", pad_oe, 1'b1);
    set_en('1);
    quiet_inputs();
    wait_n(2);
  endtask

  task automatic t_open_drain();
    quiet_inputs();
    set_cfg(2'b00, 1'b0);
    fg_ps = 2'd0; set_ps(0, 2'd0);
    wait_n(2);
    chk("R4 released on request", pad_oe, 1'b0);
    chk("R4 never drives high", pad_do, 1'b0);
    wait_n(4);
    chk("R7 amp on via pull-up", amp_en, 1'b1);
    ext_drv = 1'b1; ext_lvl = 1'b0;
    wait_n(2);
    chk("R7 not yet synchronized", amp_en, 1'b1);
    wait_n(3);
    chk("R7 external low mutes", amp_en, 1'b0);
    ext_drv = 1'b0;
    set_ps(0, 2'd3);
    wait_n(2);
    chk("R4 low when idle oe", pad_oe, 1'b1);
    chk("R4 low when idle do", pad_do, 1'b0);
    quiet_inputs();
    wait_n(4);
  endtask

  task automatic t_push_pull();
    quiet_inputs();
    set_cfg(2'b01, 1'b0);
    wait_n(1);
    chk("R5 drives when idle", pad_oe, 1'b1);
    chk("R5 drives low idle", pad_do, 1'b0);
    fg_ps = 2'd1; set_ps(3, 2'd0);
    wait_n(1);
    chk("R10 one clock latency", pad_do, 1'b1);
    chk("R5 drives high on request", pad_oe, 1'b1);
    wait_n(4);
    chk("R7 amp on in push-pull", amp_en, 1'b1);
    quiet_inputs();
    wait_n(4);
  endtask

  task automatic t_input();
    for (int m = 2; m < 4; m++) begin
      quiet_inputs();
      set_cfg(2'(m), 1'b0);
      set_en('1);
      fg_ps = 2'd0; port_ps = '0;
      wait_n(2);
      chk("R6 not driven with requests", pad_oe, 1'b0);
      set_en('0);
      wait_n(1);
      chk("R6 not driven with enables off", pad_oe, 1'b0);
      ext_drv = 1'b1; ext_lvl = 1'b1;
      wait_n(5);
      chk("R7 input high enables amp", amp_en, 1'b1);
      ext_lvl = 1'b0;
      set_en('1);
      wait_n(5);
      chk("R6 enables ignored amp off", amp_en, 1'b0);
      chk("R6 still released", pad_oe, 1'b0);
    end
    quiet_inputs();
    set_en('1);
    set_cfg(2'b00, 1'b0);
    wait_n(4);
  endtask

  task automatic t_src();
    quiet_inputs();
    set_cfg(2'b00, 1'b1);
    fg_ps = 2'd0; set_ps(0, 2'd1);
    wait_n(2);
    chk("R8 awake port enables amp", amp_en, 1'b1);
    ext_drv = 1'b1; ext_lvl = 1'b0;
    wait_n(5);
    chk("R8 pad low ignored", amp_en, 1'b1);
    set_ps(0, 2'd3); set_ps(1, 2'd0);
    wait_n(2);
    chk("R8 other port does not count", amp_en, 1'b0);
    set_ps(0, 2'd0); fg_ps = 2'd3;
    wait_n(2);
    chk("R8 fg D3 disables", amp_en, 1'b0);
    quiet_inputs();
    set_cfg(2'b00, 1'b0);
    wait_n(4);
  endtask

  task automatic t_retain();
    quiet_inputs();
    set_cfg(2'b01, 1'b1);
    set_en('0);
    fg_ps = 2'd0; set_ps(1, 2'd0);
    link_rst = 1'b1;
    wait_n(2);
    link_rst = 1'b0;
    wait_n(1);
    chk("R9 push-pull kept oe", pad_oe, 1'b1);
    chk("R3 link reset enables back", pad_do, 1'b1);
    wait_n(4);
    chk("R9 control source kept", amp_en, 1'b0);
    por_rst = 1'b1;
    wait_n(2);
    por_rst = 1'b0;
    wait_n(1);
    chk("R9 por open-drain released", pad_oe, 1'b0);
    chk("R9 por open-drain do", pad_do, 1'b0);
    wait_n(4);
    chk("R9 por source back to pad", amp_en, 1'b1);
    quiet_inputs();
    wait_n(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(1);
    t_reset();
    t_ports();
    t_open_drain();
    t_push_pull();
    t_input();
    t_src();
    t_retain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule